// File: doc/BRIEF.md
# Masked RTC Alarm Comparator

This block sits beside a real-time clock counter and decides, once per one-second tick, whether the current time matches a programmed alarm. It holds four alarm bytes, for seconds, minutes, hours and date, in BCD. Each byte also carries one mask bit. The four mask bits form a 4-bit code that selects how often the alarm repeats: every second, on a seconds match, on a minutes-and-seconds match, on a full time match, or on a date-and-time match. Any code outside those five acts as once per second, so a wrong setting is easy to spot.

When an alarm hits, a sticky flag is set. The host reads the flag through the control register, and that read clears it. A separate interrupt output follows the flag, but only when it is enabled. The normal enable allows it at any time. A second enable allows it only while the system runs in backup mode.

The host uses a simple register port. A write takes one clock. Read data is combinational from the read address. Only a read with its strobe asserted has a side effect.

Top module: `alarm_cmp`

## Requirements
- R1: After reset, every register address reads 0x00, the alarm flag is 0 and alarmIrq is 0.
- R2: Writes to addresses 2h, 3h, 4h and 5h store the full byte as the seconds, minutes, hours and date alarm bytes respectively. Bit 7 of each byte is its mask bit, and bits 6:0 hold the BCD value. rdData always reflects rdAddr, whether or not rdEn is set. Addresses other than 2h–6h read 0x00, and writes to them change nothing.
- R3: With mask code {date bit7, hour bit7, min bit7, sec bit7} equal to 1111, every tick sets the flag.
- R4: With code 1110, a tick sets the flag when timeSec equals bits 6:0 of the seconds alarm byte.
- R5: With code 1100, a tick sets the flag when both seconds and minutes match.
- R6: With code 1000, a tick sets the flag when seconds, minutes and hours all match.
- R7: With code 0000, a tick sets the flag only when seconds, minutes, hours and date all match.
- R8: Without a tick, the flag is never set, even when the fields match. The flag becomes visible one clock after the tick is sampled.
- R9: The flag is sticky. A read of address 6h with rdEn set returns the flag in bit 0 and clears it at the next clock edge. If a setting tick arrives in the same cycle as that read, the flag stays set.
- R10: Address 6h holds the flag enable in bit 7 and the backup enable in bit 6, and both are writable. alarmIrq is 1 when the flag is set and the flag enable is 1.
- R11: alarmIrq is also 1 when the flag is set, the backup enable is 1 and backup is 1. When backup is 0, the backup enable alone does not raise alarmIrq.
- R12: Any mask code other than 1111, 1110, 1100, 1000 and 0000 sets the flag on every tick, whatever the time fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update strobe |
| backup | input | 1 | High while the system runs in backup mode |
| timeSec | input | 7 | Current seconds, BCD |
| timeMin | input | 7 | Current minutes, BCD |
| timeHour | input | 7 | Current hours, BCD |
| timeDate | input | 7 | Current date, BCD |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 8 | Register write data |
| rdEn | input | 1 | Register read strobe; a read of 6h clears the flag |
| rdAddr | input | 4 | Register read address |
| rdData | output | 8 | Register read data |
| alarmIrq | output | 1 | Enabled alarm interrupt |

## Verification
The bench sets each field to match or mismatch independently, so a design that compares the wrong subset of fields for a given mask code sets the flag when it should not, or misses a hit. Codes outside the five legal values are drawn at random; a design that treats them as "never" or as a full match leaves the flag clear. A tick that lands in the same cycle as a clearing read checks the set-over-clear priority; a design that gets it wrong loses the event. Matching fields with no tick, and the backup enable with backup low, check that nothing fires when it should not.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

  localparam int NUM_FIELDS = 4;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrAlm;
    logic                  wrCtrl;
    logic                  rdClr;
  } strobe_t;

  typedef enum logic [2:0] {
    RATE_EVERY,
    RATE_S,
    RATE_MS,
    RATE_HMS,
    RATE_DHMS
  } rate_e;

  function automatic rate_e decodeRate(input logic [NUM_FIELDS-1:0] code);
    rate_e r;
    case (code)
      4'b1110: r = RATE_S;
      4'b1100: r = RATE_MS;
      4'b1000: r = RATE_HMS;
      4'b0000: r = RATE_DHMS;
      default: r = RATE_EVERY;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alarm_cmp_ctrl.sv
module alarm_cmp_ctrl
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int ALM_BASE = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  backup,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [NUM_FIELDS-1:0] fieldEq,
  input  logic [NUM_FIELDS-1:0] maskCode,
  input  logic                  ctrlAe,
  input  logic                  ctrlAbe,
  output strobe_t               strb,
  output logic                  flagQ,
  output logic                  alarmIrq
);

  localparam int CTRL_ADDR = ALM_BASE + NUM_FIELDS;

  rate_e rate;
  logic  hit;

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      strb.wrAlm[i] = wrEn && (wrAddr == ADDR_W'(ALM_BASE + i));
    end
    strb.wrCtrl = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
    strb.rdClr  = rdEn && (rdAddr == ADDR_W'(CTRL_ADDR));
  end

  assign rate = decodeRate(maskCode);

  always_comb begin
    case (rate)
      RATE_S:    hit = fieldEq[0];
      RATE_MS:   hit = &fieldEq[1:0];
      RATE_HMS:  hit = &fieldEq[2:0];
      RATE_DHMS: hit = &fieldEq;
      default:   hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (tick && hit) begin
      flagQ <= 1'b1;
    end else if (strb.rdClr) begin
      flagQ <= 1'b0;
    end
  end

  assign alarmIrq = flagQ && (ctrlAe || (ctrlAbe && backup));

endmodule

// File: rtl/alarm_cmp_dp.sv
module alarm_cmp_dp
  import alarm_cmp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int ALM_BASE = 2,
  localparam int VAL_W   = DATA_W - 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strb,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [ADDR_W-1:0]               rdAddr,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0] curTime,
  input  logic                            flagQ,
  output logic [NUM_FIELDS-1:0]           fieldEq,
  output logic [NUM_FIELDS-1:0]           maskCode,
  output logic [DATA_W-1:0]               secByte,
  output logic                            ctrlAe,
  output logic                            ctrlAbe,
  output logic [DATA_W-1:0]               rdData
);

  localparam int CTRL_ADDR = ALM_BASE + NUM_FIELDS;

  logic [DATA_W-1:0] almQ [NUM_FIELDS];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN) begin
        almQ[i] <= '0;
      end else if (strb.wrAlm[i]) begin
        almQ[i] <= wrData;
      end
    end
    assign fieldEq[i]  = (curTime[i] == almQ[i][VAL_W-1:0]);
    assign maskCode[i] = almQ[i][DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlAe  <= 1'b0;
      ctrlAbe <= 1'b0;
    end else if (strb.wrCtrl) begin
      ctrlAe  <= wrData[DATA_W-1];
      ctrlAbe <= wrData[DATA_W-2];
    end
  end

  assign secByte = almQ[0];

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rdAddr == ADDR_W'(ALM_BASE + i)) rdData = almQ[i];
    end
    if (rdAddr == ADDR_W'(CTRL_ADDR)) begin
      rdData = {ctrlAe, ctrlAbe, {(DATA_W-3){1'b0}}, flagQ};
    end
  end

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int ALM_BASE = 2,
  localparam int VAL_W   = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              backup,
  input  logic [VAL_W-1:0]  timeSec,
  input  logic [VAL_W-1:0]  timeMin,
  input  logic [VAL_W-1:0]  timeHour,
  input  logic [VAL_W-1:0]  timeDate,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq
);

  strobe_t                             strb;
  logic [NUM_FIELDS-1:0][VAL_W-1:0]    curTime;
  logic [NUM_FIELDS-1:0]               fieldEq;
  logic [NUM_FIELDS-1:0]               maskCode;
  logic [DATA_W-1:0]                   secByte;
  logic                                ctrlAe;
  logic                                ctrlAbe;
  logic                                flagQ;

  assign curTime = {timeDate, timeHour, timeMin, timeSec};

  alarm_cmp_ctrl #(
    .ADDR_W  (ADDR_W),
    .ALM_BASE(ALM_BASE)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .backup  (backup),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .fieldEq (fieldEq),
    .maskCode(maskCode),
    .ctrlAe  (ctrlAe),
    .ctrlAbe (ctrlAbe),
    .strb    (strb),
    .flagQ   (flagQ),
    .alarmIrq(alarmIrq)
  );

  alarm_cmp_dp #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .ALM_BASE(ALM_BASE)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .curTime (curTime),
    .flagQ   (flagQ),
    .fieldEq (fieldEq),
    .maskCode(maskCode),
    .secByte (secByte),
    .ctrlAe  (ctrlAe),
    .ctrlAbe (ctrlAbe),
    .rdData  (rdData)
  );

endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int ALM_BASE = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              backup,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [3:0]        maskCode,
  input logic [DATA_W-1:0] secByte,
  input logic              ctrlAbe,
  input logic              flagQ,
  input logic              alarmIrq
);

  localparam int CTRL_ADDR = ALM_BASE + 4;

  a_r2_sec_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(ALM_BASE)) |=> (secByte == $past(wrData)));

  a_r3_every_tick: assert property (@(posedge clk) disable iff (!rstN)
    (tick && maskCode == 4'b1111) |=> flagQ);

  a_r8_set_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(tick));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_W'(CTRL_ADDR) && !tick) |=> !flagQ);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> flagQ);

  a_r11_backup_irq: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && ctrlAbe && backup) |-> alarmIrq);

endmodule

bind alarm_cmp alarm_cmp_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .ALM_BASE(ALM_BASE)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .backup  (backup),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .rdEn    (rdEn),
  .rdAddr  (rdAddr),
  .maskCode(maskCode),
  .secByte (secByte),
  .ctrlAbe (ctrlAbe),
  .flagQ   (flagQ),
  .alarmIrq(alarmIrq)
);

// File: tb/alarm_cmp_tb_top.sv
`timescale 1ns/1ps
module alarm_cmp_tb_top;

  localparam int CTRL = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       backup = 1'b0;
  logic [6:0] timeSec = '0, timeMin = '0, timeHour = '0, timeDate = '0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       alarmIrq;

  int checks = 0;
  int errors = 0;
  bit expFlag = 1'b0;

  always #4 clk = ~clk;

  alarm_cmp dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .backup(backup),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour), .timeDate(timeDate),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .alarmIrq(alarmIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit expHit(input logic [3:0] code, input logic [3:0] eq);
    case (code)
      4'b1110: return eq[0];
      4'b1100: return &eq[1:0];
      4'b1000: return &eq[2:0];
      4'b0000: return &eq;
      default: return 1'b1;
    endcase
  endfunction

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic readClr();
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 4'(CTRL);
    @(negedge clk);
    rdEn = 1'b0;
    expFlag = 1'b0;
  endtask

  task automatic doTick(input bit hit);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (hit) expFlag = 1'b1;
  endtask

  task automatic setAlarm(input logic [3:0] code, input logic [3:0][6:0] v);
    for (int i = 0; i < 4; i++) writeReg(4'(2 + i), {code[i], v[i]});
  endtask

  task automatic checkFlag(input string req);
    logic [7:0] d;
    peek(4'(CTRL), d);
    check(d[0] == expFlag, req, d[0], expFlag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [3:0][6:0] v;
    logic [3:0] eq;
    logic [3:0] code;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      peek(4'(a), d);
      check(d == 8'h00, "R1 reset read", d, 0);
    end
    check(alarmIrq == 1'b0, "R1 reset irq", alarmIrq, 0);

    // R2 store, readback, ignored addresses
    writeReg(4'd3, 8'hA5);
    peek(4'd3, d); check(d == 8'hA5, "R2 min byte", d, 8'hA5);
    writeReg(4'd1, 8'hFF);
    writeReg(4'd7, 8'hFF);
    peek(4'd1, d); check(d == 8'h00, "R2 addr1 ignored", d, 0);
    peek(4'd7, d); check(d == 8'h00, "R2 addr7 ignored", d, 0);
    peek(4'd3, d); check(d == 8'hA5, "R2 min byte unchanged", d, 8'hA5);
    peek(4'(CTRL), d); check(d == 8'h00, "R2 ctrl unchanged", d, 0);

    // R8 matching fields without tick: no set
    v = {7'h15, 7'h12, 7'h34, 7'h56};
    setAlarm(4'b0000, v);
    {timeDate, timeHour, timeMin, timeSec} = v;
    repeat (5) @(negedge clk);
    checkFlag("R8 no tick no set");
    doTick(1'b1);
    checkFlag("R7 full match sets");

    // R9 sticky, read clears
    repeat (3) @(negedge clk);
    checkFlag("R9 sticky");
    readClr();
    checkFlag("R9 read clears");

    // R7 one field off
    timeDate = 7'h16;
    doTick(1'b0);
    checkFlag("R7 date mismatch");

    // R9 set wins over same-cycle clear
    setAlarm(4'b1111, v);
    @(negedge clk);
    tick = 1'b1; rdEn = 1'b1; rdAddr = 4'(CTRL);
    @(negedge clk);
    tick = 1'b0; rdEn = 1'b0;
    expFlag = 1'b1;
    checkFlag("R9 set beats clear");

    // R10 / R11 interrupt gating
    check(alarmIrq == 1'b0, "R10 no enable no irq", alarmIrq, 0);
    writeReg(4'(CTRL), 8'h80);
    #1 check(alarmIrq == 1'b1, "R10 flag enable irq", alarmIrq, 1);
    peek(4'(CTRL), d); check(d == 8'h81, "R10 ctrl readback", d, 8'h81);
    writeReg(4'(CTRL), 8'h40);
    backup = 1'b0;
    #1 check(alarmIrq == 1'b0, "R11 backup enable idle", alarmIrq, 0);
    backup = 1'b1;
    #1 check(alarmIrq == 1'b1, "R11 backup enable in backup", alarmIrq, 1);
    readClr();
    #1 check(alarmIrq == 1'b0, "R11 irq drops after clear", alarmIrq, 0);
    backup = 1'b0;
    writeReg(4'(CTRL), 8'h00);

    // R3..R7, R12 random
    for (int it = 0; it < 300; it++) begin
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: code = 4'b1111;
        1: code = 4'b1110;
        2: code = 4'b1100;
        3: code = 4'b1000;
        4: code = 4'b0000;
        default: code = 4'($urandom);
      endcase
      for (int i = 0; i < 4; i++) v[i] = 7'($urandom);
      setAlarm(code, v);
      for (int i = 0; i < 4; i++) begin
        eq[i] = 1'($urandom);
      end
      timeSec  = eq[0] ? v[0] : v[0] ^ 7'($urandom_range(1, 127));
      timeMin  = eq[1] ? v[1] : v[1] ^ 7'($urandom_range(1, 127));
      timeHour = eq[2] ? v[2] : v[2] ^ 7'($urandom_range(1, 127));
      timeDate = eq[3] ? v[3] : v[3] ^ 7'($urandom_range(1, 127));
      doTick(expHit(code, eq));
      case (code)
        4'b1111: checkFlag("R3 every tick");
        4'b1110: checkFlag("R4 seconds match");
        4'b1100: checkFlag("R5 min sec match");
        4'b1000: checkFlag("R6 hms match");
        4'b0000: checkFlag("R7 full match");
        default: checkFlag("R12 illegal code");
      endcase
      if ($urandom_range(0, 1) == 1) begin
        readClr();
        checkFlag("R9 random clear");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule